// File: doc/BRIEF.md
# Parallel Handoff Handshake State Tracker

This block sits beside a load port and watches the ten boolean lines of the parallel handshake between a material-handling vehicle and the equipment. Each line passes through a two-flop synchroniser. The synchronised levels are then held in a ten-bit line map.

On every clock the block evaluates the line map against a fixed priority and produces one handshake state. The state depends only on the current line levels, not on the order in which they arrived. When the evaluated state differs from the registered one, the block raises a one-cycle event. The event carries the previous state, the new state and the lowest-numbered line that changed.

A synchronous soft clear empties the synchroniser and the map, and returns the state to idle without raising an event.

Top module: `hs_tracker`

## Requirements
- R1: While rst_ni is low and after it is released with all lines low, lines_o reads 0, state_o reads 0 (idle) and evt_o is low.
- R2: The line bit positions are: 0 select-A, 1 select-B, 2 valid, 3 transfer-request, 4 busy, 5 complete, 6 load-request, 7 unload-request, 8 ready, 9 emergency-stop. A change on lines_i appears on lines_o and state_o at the third rising clock edge after it is applied, and not before.
- R3: State codes are 0 idle, 1 carrier-present, 2 valid, 3 load-ready, 4 unload-ready, 5 transferring, 6 complete, 7 emergency-stop. With emergency-stop low, complete high gives 6 even if busy is high, and busy high gives 5 whatever valid and the request lines are doing.
- R4: Emergency-stop high gives state 7 regardless of every other line, and the state stays 7 while other lines drop.
- R5: When emergency-stop clears, the state is recomputed from the remaining lines. With valid and both select lines low, the result is 0 even if load-request is still high.
- R6: Either select line (or both), with valid, busy, complete and emergency-stop low, gives 1. Adding valid gives 2.
- R7: Valid with load-request gives 3. Valid with unload-request gives 4. If both request lines are high, the result is 3.
- R8: A full load sequence (select, valid, load-request, busy set, busy clear, complete) produces exactly six events, ending in 1, 2, 3, 5, 3 and 6 in turn.
- R9: A state change raises evt_o for exactly one cycle. In that cycle evt_new_o equals state_o, evt_old_o equals the state before the change, and evt_line_o names the lowest-numbered line whose level changed.
- R10: No event is raised when the state does not change. This covers rewriting a line to its present level and changing lines such as ready or transfer-request that do not alter the evaluated state.
- R11: A high soft_clr_i clears lines_o and state_o to 0 at the next rising edge, with no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| soft_clr_i | input | 1 | Synchronous clear of lines and state |
| lines_i | input | 10 | Asynchronous handshake lines |
| lines_o | output | 10 | Registered line map |
| state_o | output | 3 | Current handshake state |
| evt_o | output | 1 | One-cycle state-change pulse |
| evt_old_o | output | 3 | State before the change |
| evt_new_o | output | 3 | State after the change |
| evt_line_o | output | 4 | Lowest-numbered changed line |

## Verification
Several properties are checked on every cycle: emergency-stop dominance over the registered map, event consistency (new state equals the current state, old state equals the prior one, and the two differ), state stability between events, and the effect of soft clear. The bench's scenarios cover the rest. These are the exact priority outcomes for specific line mixes, the lowest-changed-line cause, the three-edge latency, the count of six events over a load sequence, and the absence of events for no-op writes.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int NUM_LINES  = 10;
  localparam int LINE_IDX_W = $clog2(NUM_LINES);
  localparam int SYNC_DEPTH = 2;

  localparam int L_SEL_A   = 0;
  localparam int L_SEL_B   = 1;
  localparam int L_VALID   = 2;
  localparam int L_XREQ    = 3;
  localparam int L_BUSY    = 4;
  localparam int L_DONE    = 5;
  localparam int L_LDREQ   = 6;
  localparam int L_ULREQ   = 7;
  localparam int L_READY   = 8;
  localparam int L_ESTOP   = 9;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CARRIER = 3'd1,
    ST_VALID   = 3'd2,
    ST_LOAD    = 3'd3,
    ST_UNLOAD  = 3'd4,
    ST_XFER    = 3'd5,
    ST_DONE    = 3'd6,
    ST_ESTOP   = 3'd7
  } hs_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int WIDTH  = 10,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    stage_q[0] <= '0;
        else if (clr_i) stage_q[0] <= '0;
        else            stage_q[0] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    stage_q[s] <= '0;
        else if (clr_i) stage_q[s] <= '0;
        else            stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hs_eval.sv
module hs_eval
  import hs_pkg::*;
(
  input  logic [NUM_LINES-1:0] map_i,
  output hs_state_e            state_o
);
  always_comb begin
    if (map_i[L_ESTOP])                        state_o = ST_ESTOP;
    else if (map_i[L_DONE])                    state_o = ST_DONE;
    else if (map_i[L_BUSY])                    state_o = ST_XFER;
    else if (map_i[L_VALID] && map_i[L_LDREQ]) state_o = ST_LOAD;
    else if (map_i[L_VALID] && map_i[L_ULREQ]) state_o = ST_UNLOAD;
    else if (map_i[L_VALID])                   state_o = ST_VALID;
    else if (map_i[L_SEL_A] || map_i[L_SEL_B]) state_o = ST_CARRIER;
    else                                       state_o = ST_IDLE;
  end
endmodule

// File: rtl/hs_cause.sv
module hs_cause
  import hs_pkg::*;
(
  input  logic [NUM_LINES-1:0]  diff_i,
  output logic [LINE_IDX_W-1:0] idx_o
);
  // scan downward so the lowest set bit is written last
  always_comb begin
    idx_o = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (diff_i[i]) idx_o = LINE_IDX_W'(i);
    end
  end
endmodule

// File: rtl/hs_tracker.sv
module hs_tracker
  import hs_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  soft_clr_i,
  input  logic [NUM_LINES-1:0]  lines_i,
  output logic [NUM_LINES-1:0]  lines_o,
  output logic [2:0]            state_o,
  output logic                  evt_o,
  output logic [2:0]            evt_old_o,
  output logic [2:0]            evt_new_o,
  output logic [LINE_IDX_W-1:0] evt_line_o
);
  logic [NUM_LINES-1:0]  sync_w;
  logic [NUM_LINES-1:0]  map_q;
  hs_state_e             next_w, state_q, evt_old_q, evt_new_q;
  logic [LINE_IDX_W-1:0] cause_w, evt_line_q;
  logic                  evt_q;

  hs_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_DEPTH)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(soft_clr_i),
    .d_i(lines_i), .q_o(sync_w)
  );

  hs_eval u_eval (.map_i(sync_w), .state_o(next_w));

  hs_cause u_cause (.diff_i(sync_w ^ map_q), .idx_o(cause_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q      <= '0;
      state_q    <= ST_IDLE;
      evt_q      <= 1'b0;
      evt_old_q  <= ST_IDLE;
      evt_new_q  <= ST_IDLE;
      evt_line_q <= '0;
    end else if (soft_clr_i) begin
      map_q      <= '0;
      state_q    <= ST_IDLE;
      evt_q      <= 1'b0;
    end else begin
      map_q   <= sync_w;
      state_q <= next_w;
      evt_q   <= (next_w != state_q);
      if (next_w != state_q) begin
        evt_old_q  <= state_q;
        evt_new_q  <= next_w;
        evt_line_q <= cause_w;
      end
    end
  end

  assign lines_o    = map_q;
  assign state_o    = state_q;
  assign evt_o      = evt_q;
  assign evt_old_o  = evt_old_q;
  assign evt_new_o  = evt_new_q;
  assign evt_line_o = evt_line_q;

  AST_ESTOP_DOMINATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_q[L_ESTOP] |-> state_q == ST_ESTOP); // R4
  AST_EVT_NEW_IS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> evt_new_q == state_q); // R9
  AST_EVT_OLD_IS_PRIOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> evt_old_q == $past(state_q)); // R9
  AST_EVT_REAL_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> evt_old_q != evt_new_q); // R10
  AST_QUIET_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_q && !$past(soft_clr_i)) |-> $stable(state_q)); // R10
  AST_SOFT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr_i |=> (state_q == ST_IDLE && map_q == '0 && !evt_q)); // R11
endmodule

// File: tb/tb_hs_tracker.sv
module tb_hs_tracker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_clr = 1'b0;
  logic [9:0] lines = '0;
  logic [9:0] lines_q;
  logic [2:0] state, ev_old, ev_new;
  logic       ev;
  logic [3:0] ev_line;
  int checks = 0, fails = 0, ev_count = 0;

  always #2 clk = ~clk;

  hs_tracker dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_clr_i(soft_clr), .lines_i(lines),
    .lines_o(lines_q), .state_o(state), .evt_o(ev), .evt_old_o(ev_old),
    .evt_new_o(ev_new), .evt_line_o(ev_line)
  );

  always @(posedge clk) if (rst_n && ev) ev_count++;

  // {lines, state, evt, old, cause line}
  typedef struct packed {
    logic [9:0] ln; logic [2:0] st; logic e; logic [2:0] old; logic [3:0] cause;
  } vec_t;
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{10'h001, 3'd1, 1'b1, 3'd0, 4'd0},  // R6 select-A
    '{10'h005, 3'd2, 1'b1, 3'd1, 4'd2},  // R6 valid
    '{10'h045, 3'd3, 1'b1, 3'd2, 4'd6},  // R7 load
    '{10'h055, 3'd5, 1'b1, 3'd3, 4'd4},  // R3 busy
    '{10'h045, 3'd3, 1'b1, 3'd5, 4'd4},  // R8 busy drop
    '{10'h065, 3'd6, 1'b1, 3'd3, 4'd5},  // R8 complete
    '{10'h065, 3'd6, 1'b0, 3'd0, 4'd0},  // R10 no-op
    '{10'h000, 3'd0, 1'b1, 3'd6, 4'd0},  // R9 lowest cause
    '{10'h002, 3'd1, 1'b1, 3'd0, 4'd1},  // R6 select-B
    '{10'h086, 3'd4, 1'b1, 3'd1, 4'd2},  // R7 unload
    '{10'h0C6, 3'd3, 1'b1, 3'd4, 4'd6},  // R7 both requests
    '{10'h2C6, 3'd7, 1'b1, 3'd3, 4'd9},  // R4 estop
    '{10'h2C0, 3'd7, 1'b0, 3'd0, 4'd0},  // R4 lines drop
    '{10'h0C0, 3'd0, 1'b1, 3'd7, 4'd9},  // R5 recompute
    '{10'h108, 3'd0, 1'b0, 3'd0, 4'd0},  // R10 ready/xreq only
    '{10'h003, 3'd1, 1'b1, 3'd0, 4'd0},  // R6 both selects
    '{10'h037, 3'd6, 1'b1, 3'd1, 4'd2},  // R3 complete over busy
    '{10'h017, 3'd5, 1'b1, 3'd6, 4'd5}   // R3 busy
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    cyc(3);
    chk("R1 state", state, 0);
    chk("R1 lines", lines_q, 0);
    chk("R1 evt", ev, 0);
    rst_n = 1'b1;
    cyc(2);
    chk("R1 after release", {lines_q, state, ev}, 0);

    base = ev_count;
    for (int i = 0; i < NV; i++) begin
      lines = VECS[i].ln;
      cyc(3);
      chk($sformatf("R9 v%0d state", i), state, VECS[i].st);
      chk($sformatf("R9 v%0d evt", i), ev, VECS[i].e);
      if (VECS[i].e) begin
        chk($sformatf("R9 v%0d old", i), ev_old, VECS[i].old);
        chk($sformatf("R9 v%0d new", i), ev_new, VECS[i].st);
        chk($sformatf("R9 v%0d cause", i), ev_line, VECS[i].cause);
      end
      cyc(1);
      chk($sformatf("R9 v%0d pulse ends", i), ev, 0);
      if (i == 5) chk("R8 six events", ev_count - base, 6);
    end

    // R2 latency
    lines = 10'h000;
    cyc(4);
    lines = 10'h001;
    cyc(2);
    chk("R2 not before third edge", state, 0);
    chk("R2 lines not before third edge", lines_q, 0);
    cyc(1);
    chk("R2 state at third edge", state, 1);
    chk("R2 lines at third edge", lines_q, 10'h001);

    // R11 soft clear
    lines = 10'h045;
    cyc(4);
    chk("R11 setup", state, 3);
    base = ev_count;
    lines = 10'h000;
    soft_clr = 1'b1;
    cyc(1);
    soft_clr = 1'b0;
    chk("R11 state", state, 0);
    chk("R11 lines", lines_q, 0);
    cyc(4);
    chk("R11 no event", ev_count - base, 0);
    chk("R11 stays idle", state, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule